// File: doc/BRIEF.md
# Rename History Log with Rollback

This block keeps an ordered log of the register-rename decisions made by an out-of-order core. Each record ties an instruction sequence number to one architectural destination register, the physical register just allocated for it and the physical register it displaced. An instruction that writes no register leaves a single placeholder record that carries only its sequence number, so that the log stays in program order. The rename stage appends records at the newest end and treats the `full` flag as a stall condition.

The log is unwound from either end. A squash request walks back from the newest end. For each real record it removes, it drives a restore of the map table and returns the speculatively allocated register to the free list. A commit request walks forward from the oldest end and returns each displaced register to the free list. Each walk handles at most one record per clock. `busy` stays high until the walk has finished. A squash that arrives together with a commit, or during a commit walk, runs first, and the commit is kept and resumed afterwards. Four event counters record placeholders inserted, real maps committed, records undone and real maps undone.

Top module: `rename_hist_log`

## Requirements
- R1: A push that is accepted stores one record at the newest end and clears `empty`. When the log holds DEPTH (default 32) records, `full` is 1 and a further push is dropped. Commit walks return records in the order they were pushed.
- R2: A record pushed with `push_placeholder`=1 is removed by commit or squash like any other record, but it never drives `restore_valid` or `free_valid`.
- R3: Squash with sequence Q removes records from the newest end while the newest record's sequence is greater than Q (unsigned compare), at one record per clock and newest first. For each real record removed, one cycle shows `restore_valid`=1 with `restore_areg`/`restore_preg` equal to its architectural and previous physical register, and `free_valid`=1 with `free_preg` equal to its new physical register.
- R4: A squash request that arrives while the log is empty does nothing: `busy` stays 0 and no output strobe appears.
- R5: Commit with sequence S removes records from the oldest end while the oldest record's sequence is at most S, so every record of S is included. Each real record removed drives `free_valid`=1 with `free_preg` equal to its previous physical register, oldest first.
- R6: A commit whose S is smaller than the oldest record's sequence removes nothing and produces no strobe.
- R7: When squash and commit arrive in the same cycle, the whole squash walk completes before any commit output. The commit is then carried out without `busy` dropping in between.
- R8: `busy` is 1 from the cycle after a request is accepted until its walk is complete. A push in a cycle that carries a squash request, or during a squash walk, is dropped.
- R9: `cnt_placeholders` counts accepted placeholder pushes. `cnt_commits` counts real records removed by commit. `cnt_undos` counts all records removed by squash. `cnt_undos_real` counts the real ones among them.
- R10: After reset the log is empty, `full`, `busy` and both strobes are 0, and all counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Append a record this cycle |
| push_seq | input | SEQ_W | Sequence number of the record |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly allocated physical register |
| push_old_preg | input | PREG_W | Physical register previously mapped |
| push_placeholder | input | 1 | Record is a placeholder with no destination |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| restore_valid | output | 1 | Map-table restore strobe |
| restore_areg | output | AREG_W | Register whose mapping is restored |
| restore_preg | output | PREG_W | Physical register restored into the map |
| free_valid | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register returned |
| full | output | 1 | Log holds DEPTH records |
| empty | output | 1 | Log holds no record |
| busy | output | 1 | A squash or commit walk is in progress |
| cnt_placeholders | output | CNT_W | Placeholder insert count |
| cnt_commits | output | CNT_W | Real maps committed |
| cnt_undos | output | CNT_W | Records undone by squash |
| cnt_undos_real | output | CNT_W | Real maps undone by squash |

## Verification
A corrupted pointer or occupancy count in this log shows up at the ports within one walk. It appears as a restore or free strobe carrying the wrong register, as a strobe from the wrong end (a previous register where a new one was due), or as a walk that ends early or late. Each scenario therefore runs a complete walk and compares the ordered list of strobes it produced against the records the bench pushed. The runs also cover the cases where nothing should appear: a stale commit, a squash on an empty log, and pushes dropped during a squash. In each of these the absence is confirmed by a later walk that would expose any stray record.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
   typedef enum logic [1:0] {
      WALK_IDLE   = 2'd0,
      WALK_SQUASH = 2'd1,
      WALK_COMMIT = 2'd2
   } walk_e;

   localparam int EV_PH        = 0;
   localparam int EV_CMT       = 1;
   localparam int EV_UNDO      = 2;
   localparam int EV_UNDO_REAL = 3;
   localparam int EV_COUNT     = 4;
endpackage

// File: rtl/rhl_store.sv
module rhl_store #(
   parameter int DEPTH = 32,
   parameter int REC_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_en,
   input  logic [REC_W-1:0] push_rec,
   input  logic             pop_old,
   input  logic             pop_new,
   output logic [REC_W-1:0] oldest_rec,
   output logic [REC_W-1:0] newest_rec,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [REC_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] fill_q;

   always_ff @(posedge clk) begin
      if (push_en) slots[tail_q] <= push_rec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         fill_q <= '0;
      end else begin
         tail_q <= tail_q + PTR_W'(push_en) - PTR_W'(pop_new);
         head_q <= head_q + PTR_W'(pop_old);
         fill_q <= fill_q + CNT_W'(push_en) - CNT_W'(pop_old) - CNT_W'(pop_new);
      end
   end

   assign oldest_rec = slots[head_q];
   assign newest_rec = slots[tail_q - PTR_W'(1)];
   assign empty      = (fill_q == '0);
   assign full       = (fill_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rhl_ctrl.sv
module rhl_ctrl
   import rhl_pkg::*;
#(
   parameter int SEQ_W  = 16,
   parameter int AREG_W = 5,
   parameter int PREG_W = 7,
   parameter int REC_W  = SEQ_W + AREG_W + 2 * PREG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              squash_valid,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic              commit_valid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              empty,
   input  logic [REC_W-1:0]  oldest_rec,
   input  logic [REC_W-1:0]  newest_rec,
   output logic              pop_old,
   output logic              pop_new,
   output logic              walk_busy,
   output logic              squash_active,
   output logic              restore_valid,
   output logic [AREG_W-1:0] restore_areg,
   output logic [PREG_W-1:0] restore_preg,
   output logic              free_valid,
   output logic [PREG_W-1:0] free_preg,
   output logic              ev_cmt,
   output logic              ev_undo,
   output logic              ev_undo_real
);
   typedef struct packed {
      logic [SEQ_W-1:0]  seq;
      logic [AREG_W-1:0] areg;
      logic [PREG_W-1:0] pnew;
      logic [PREG_W-1:0] pold;
      logic              ph;
   } rec_t;

   rec_t old_r, new_r;
   assign old_r = rec_t'(oldest_rec);
   assign new_r = rec_t'(newest_rec);

   logic unused_fields;
   assign unused_fields = ^{old_r.areg, old_r.pnew};

   walk_e            st_q, st_d;
   logic [SEQ_W-1:0] sq_q, sq_d;
   logic             cm_v_q, cm_v_d;
   logic [SEQ_W-1:0] cm_q, cm_d;

   always_comb begin
      st_d    = st_q;
      sq_d    = sq_q;
      cm_v_d  = cm_v_q;
      cm_d    = cm_q;
      pop_old = 1'b0;
      pop_new = 1'b0;
      if (commit_valid) begin
         cm_v_d = 1'b1;
         cm_d   = commit_seq;
      end
      unique case (st_q)
         WALK_IDLE: begin
            if (squash_valid && !empty) begin
               st_d = WALK_SQUASH;
               sq_d = squash_seq;
            end else if (cm_v_q || commit_valid) begin
               st_d = WALK_COMMIT;
            end
         end
         WALK_SQUASH: begin
            if (squash_valid) begin
               sq_d = (squash_seq < sq_q) ? squash_seq : sq_q;
            end else if (empty || new_r.seq <= sq_q) begin
               st_d = (cm_v_q || commit_valid) ? WALK_COMMIT : WALK_IDLE;
            end else begin
               pop_new = 1'b1;
            end
         end
         WALK_COMMIT: begin
            if (squash_valid && !empty) begin
               st_d = WALK_SQUASH;
               sq_d = squash_seq;
            end else if (empty || old_r.seq > cm_q) begin
               if (!commit_valid) begin
                  cm_v_d = 1'b0;
                  st_d   = WALK_IDLE;
               end
            end else begin
               pop_old = 1'b1;
            end
         end
         default: st_d = WALK_IDLE;
      endcase
   end

   assign ev_cmt       = pop_old & ~old_r.ph;
   assign ev_undo      = pop_new;
   assign ev_undo_real = pop_new & ~new_r.ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= WALK_IDLE;
         sq_q          <= '0;
         cm_v_q        <= 1'b0;
         cm_q          <= '0;
         restore_valid <= 1'b0;
         restore_areg  <= '0;
         restore_preg  <= '0;
         free_valid    <= 1'b0;
         free_preg     <= '0;
      end else begin
         st_q          <= st_d;
         sq_q          <= sq_d;
         cm_v_q        <= cm_v_d;
         cm_q          <= cm_d;
         restore_valid <= ev_undo_real;
         restore_areg  <= new_r.areg;
         restore_preg  <= new_r.pold;
         free_valid    <= ev_undo_real | ev_cmt;
         free_preg     <= pop_new ? new_r.pnew : old_r.pold;
      end
   end

   assign walk_busy     = (st_q != WALK_IDLE);
   assign squash_active = (st_q == WALK_SQUASH);
endmodule

// File: rtl/rhl_stats.sv
module rhl_stats #(
   parameter int N_EV     = 4,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_EV-1:0]       ev,
   output logic [N_EV*CNT_W-1:0] cnt
);
   for (genvar g = 0; g < N_EV; g++) begin : g_cnt
      logic [CNT_W-1:0] val_q;
      logic             at_top;
      if (SATURATE) begin : g_sat
         assign at_top = &val_q;
      end else begin : g_wrap
         assign at_top = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               val_q <= '0;
         else if (ev[g] && !at_top) val_q <= val_q + 1'b1;
      end
      assign cnt[g*CNT_W +: CNT_W] = val_q;
   end
endmodule

// File: rtl/rename_hist_log.sv
module rename_hist_log
   import rhl_pkg::*;
#(
   parameter int SEQ_W        = 16,
   parameter int AREG_W       = 5,
   parameter int PREG_W       = 7,
   parameter int DEPTH        = 32,
   parameter int CNT_W        = 16,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [SEQ_W-1:0]  push_seq,
   input  logic [AREG_W-1:0] push_areg,
   input  logic [PREG_W-1:0] push_new_preg,
   input  logic [PREG_W-1:0] push_old_preg,
   input  logic              push_placeholder,
   input  logic              commit_valid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              squash_valid,
   input  logic [SEQ_W-1:0]  squash_seq,
   output logic              restore_valid,
   output logic [AREG_W-1:0] restore_areg,
   output logic [PREG_W-1:0] restore_preg,
   output logic              free_valid,
   output logic [PREG_W-1:0] free_preg,
   output logic              full,
   output logic              empty,
   output logic              busy,
   output logic [CNT_W-1:0]  cnt_placeholders,
   output logic [CNT_W-1:0]  cnt_commits,
   output logic [CNT_W-1:0]  cnt_undos,
   output logic [CNT_W-1:0]  cnt_undos_real
);
   localparam int REC_W = SEQ_W + AREG_W + 2 * PREG_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rename_hist_log: DEPTH must be a power of two of at least 2");
   end
   if (SEQ_W < 1 || AREG_W < 1 || PREG_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("rename_hist_log: all widths must be at least 1");
   end

   logic             push_en, pop_old, pop_new, squash_active;
   logic [REC_W-1:0] push_rec, oldest_rec, newest_rec;
   logic             ev_cmt, ev_undo, ev_undo_real;
   logic [EV_COUNT-1:0]       ev_vec;
   logic [EV_COUNT*CNT_W-1:0] cnt_flat;

   assign push_rec = {push_seq, push_areg, push_new_preg, push_old_preg, push_placeholder};
   assign push_en  = push_valid & ~full & ~squash_valid & ~squash_active;

   rhl_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_en    (push_en),
      .push_rec   (push_rec),
      .pop_old    (pop_old),
      .pop_new    (pop_new),
      .oldest_rec (oldest_rec),
      .newest_rec (newest_rec),
      .empty      (empty),
      .full       (full)
   );

   rhl_ctrl #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W), .REC_W(REC_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .squash_valid  (squash_valid),
      .squash_seq    (squash_seq),
      .commit_valid  (commit_valid),
      .commit_seq    (commit_seq),
      .empty         (empty),
      .oldest_rec    (oldest_rec),
      .newest_rec    (newest_rec),
      .pop_old       (pop_old),
      .pop_new       (pop_new),
      .walk_busy     (busy),
      .squash_active (squash_active),
      .restore_valid (restore_valid),
      .restore_areg  (restore_areg),
      .restore_preg  (restore_preg),
      .free_valid    (free_valid),
      .free_preg     (free_preg),
      .ev_cmt        (ev_cmt),
      .ev_undo       (ev_undo),
      .ev_undo_real  (ev_undo_real)
   );

   always_comb begin
      ev_vec               = '0;
      ev_vec[EV_PH]        = push_en & push_placeholder;
      ev_vec[EV_CMT]       = ev_cmt;
      ev_vec[EV_UNDO]      = ev_undo;
      ev_vec[EV_UNDO_REAL] = ev_undo_real;
   end

   rhl_stats #(.N_EV(EV_COUNT), .CNT_W(CNT_W), .SATURATE(CNT_SATURATE)) u_stats (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_vec),
      .cnt   (cnt_flat)
   );

   assign cnt_placeholders = cnt_flat[EV_PH*CNT_W +: CNT_W];
   assign cnt_commits      = cnt_flat[EV_CMT*CNT_W +: CNT_W];
   assign cnt_undos        = cnt_flat[EV_UNDO*CNT_W +: CNT_W];
   assign cnt_undos_real   = cnt_flat[EV_UNDO_REAL*CNT_W +: CNT_W];
endmodule

// File: rtl/rhl_checker.sv
module rhl_checker (
   input logic clk,
   input logic rst_n,
   input logic push_valid,
   input logic commit_valid,
   input logic squash_valid,
   input logic restore_valid,
   input logic free_valid,
   input logic full,
   input logic empty,
   input logic busy
);
   AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty)); // R1

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !busy) |=> full); // R1

   AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !full && !busy && !squash_valid) |=> !empty); // R1

   AST_RESTORE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> free_valid); // R3

   AST_EMPTY_SQUASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !busy && squash_valid && !commit_valid) |=> (!busy && !restore_valid)); // R4

   AST_RESTORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      restore_valid |-> busy); // R8

   AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(squash_valid || commit_valid)); // R8
endmodule

bind rename_hist_log rhl_checker u_rhl_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .push_valid    (push_valid),
   .commit_valid  (commit_valid),
   .squash_valid  (squash_valid),
   .restore_valid (restore_valid),
   .free_valid    (free_valid),
   .full          (full),
   .empty         (empty),
   .busy          (busy)
);

// File: tb/rename_hist_log_test.sv
module rename_hist_log_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [15:0] push_seq = '0;
   logic [4:0]  push_areg = '0;
   logic [6:0]  push_new_preg = '0;
   logic [6:0]  push_old_preg = '0;
   logic        push_placeholder = 1'b0;
   logic        commit_valid = 1'b0;
   logic [15:0] commit_seq = '0;
   logic        squash_valid = 1'b0;
   logic [15:0] squash_seq = '0;
   logic        restore_valid, free_valid, full, empty, busy;
   logic [4:0]  restore_areg;
   logic [6:0]  restore_preg, free_preg;
   logic [15:0] cnt_placeholders, cnt_commits, cnt_undos, cnt_undos_real;

   int checks = 0;
   int errors = 0;
   int ev_k[$];
   int ev_a[$];
   int ev_b[$];
   int ev_c[$];

   always #2 clk = ~clk;

   rename_hist_log uut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
      .push_new_preg(push_new_preg), .push_old_preg(push_old_preg),
      .push_placeholder(push_placeholder),
      .commit_valid(commit_valid), .commit_seq(commit_seq),
      .squash_valid(squash_valid), .squash_seq(squash_seq),
      .restore_valid(restore_valid), .restore_areg(restore_areg), .restore_preg(restore_preg),
      .free_valid(free_valid), .free_preg(free_preg),
      .full(full), .empty(empty), .busy(busy),
      .cnt_placeholders(cnt_placeholders), .cnt_commits(cnt_commits),
      .cnt_undos(cnt_undos), .cnt_undos_real(cnt_undos_real)
   );

   // kind 1: restore+free, kind 2: free only
   always @(negedge clk) begin
      if (rst_n) begin
         if (restore_valid) begin
            ev_k.push_back(1); ev_a.push_back(int'(restore_areg));
            ev_b.push_back(int'(restore_preg)); ev_c.push_back(int'(free_preg));
         end else if (free_valid) begin
            ev_k.push_back(2); ev_a.push_back(0); ev_b.push_back(0);
            ev_c.push_back(int'(free_preg));
         end
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      ev_k.delete(); ev_a.delete(); ev_b.delete(); ev_c.delete();
   endtask

   task automatic push(input int seq, input int areg, input int pnew, input int pold, input bit ph);
      push_valid = 1'b1; push_seq = 16'(seq); push_areg = 5'(areg);
      push_new_preg = 7'(pnew); push_old_preg = 7'(pold); push_placeholder = ph;
      @(negedge clk);
      push_valid = 1'b0; push_placeholder = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
   endtask

   task automatic do_commit(input int seq);
      commit_valid = 1'b1; commit_seq = 16'(seq);
      @(negedge clk);
      commit_valid = 1'b0;
      wait_idle();
   endtask

   task automatic do_squash(input int seq);
      squash_valid = 1'b1; squash_seq = 16'(seq);
      @(negedge clk);
      squash_valid = 1'b0;
      wait_idle();
   endtask

   task automatic t_reset();
      check_eq("R10", "empty", int'(empty), 1);
      check_eq("R10", "full", int'(full), 0);
      check_eq("R10", "busy", int'(busy), 0);
      check_eq("R10", "strobes", int'(restore_valid | free_valid), 0);
      check_eq("R10", "counters", int'(cnt_placeholders | cnt_commits | cnt_undos | cnt_undos_real), 0);
   endtask

   task automatic t_commit_walk();
      push(1, 1, 33, 1, 1'b0);
      push(2, 0, 0, 0, 1'b1);
      push(3, 2, 34, 2, 1'b0);
      push(3, 3, 35, 3, 1'b0);
      check_eq("R1", "empty after pushes", int'(empty), 0);
      clear_log();
      do_commit(2);
      check_eq("R5", "commit strobe count", ev_k.size(), 1);
      if (ev_k.size() == 1) begin
         check_eq("R5", "commit freed prev reg", ev_c[0], 1);
         check_eq("R5", "commit strobe kind", ev_k[0], 2);
      end
      check_eq("R9", "placeholder count", int'(cnt_placeholders), 1);
      check_eq("R2", "placeholder not counted as commit", int'(cnt_commits), 1);
   endtask

   task automatic t_commit_stale();
      clear_log();
      do_commit(1);
      check_eq("R6", "stale commit strobes", ev_k.size(), 0);
      check_eq("R6", "log still holds records", int'(empty), 0);
      check_eq("R6", "commit count unchanged", int'(cnt_commits), 1);
   endtask

   task automatic t_squash_walk();
      push(4, 0, 0, 0, 1'b1);
      clear_log();
      do_squash(2);
      check_eq("R3", "squash strobe count", ev_k.size(), 2);
      if (ev_k.size() == 2) begin
         check_eq("R3", "first restore areg", ev_a[0], 3);
         check_eq("R3", "first restore preg", ev_b[0], 3);
         check_eq("R3", "first free new preg", ev_c[0], 35);
         check_eq("R3", "second restore areg", ev_a[1], 2);
         check_eq("R3", "second restore preg", ev_b[1], 2);
         check_eq("R3", "second free new preg", ev_c[1], 34);
      end
      check_eq("R3", "empty after squash", int'(empty), 1);
      check_eq("R9", "undo count", int'(cnt_undos), 3);
      check_eq("R2", "placeholder undo not real", int'(cnt_undos_real), 2);
   endtask

   task automatic t_squash_empty();
      clear_log();
      squash_valid = 1'b1; squash_seq = 16'd0;
      @(negedge clk);
      squash_valid = 1'b0;
      check_eq("R4", "busy after empty squash", int'(busy), 0);
      repeat (3) @(negedge clk);
      check_eq("R4", "busy later", int'(busy), 0);
      check_eq("R4", "no strobes", ev_k.size(), 0);
   endtask

   task automatic t_fill();
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
         if (i == 31) check_eq("R1", "full before last push", int'(full), 0);
         push(100 + i, i % 32, 64 + i, i, 1'b0);
      end
      check_eq("R1", "full at depth", int'(full), 1);
      push(200, 9, 120, 99, 1'b0);
      check_eq("R1", "still full after dropped push", int'(full), 1);
      clear_log();
      do_commit(200);
      check_eq("R1", "commit returns only stored records", ev_k.size(), 32);
      for (int i = 0; i < ev_k.size(); i++) begin
         if (ev_k[i] != 2 || ev_c[i] != i) bad++;
      end
      check_eq("R5", "oldest-first free order mismatches", bad, 0);
      check_eq("R5", "empty after full commit", int'(empty), 1);
   endtask

   task automatic t_priority();
      push(10, 4, 40, 4, 1'b0);
      push(11, 5, 41, 5, 1'b0);
      push(12, 6, 42, 6, 1'b0);
      clear_log();
      squash_valid = 1'b1; squash_seq = 16'd11;
      commit_valid = 1'b1; commit_seq = 16'd10;
      @(negedge clk);
      squash_valid = 1'b0; commit_valid = 1'b0;
      wait_idle();
      check_eq("R7", "strobe count", ev_k.size(), 2);
      if (ev_k.size() == 2) begin
         check_eq("R7", "squash first", ev_k[0], 1);
         check_eq("R7", "squash restore preg", ev_b[0], 6);
         check_eq("R7", "squash free preg", ev_c[0], 42);
         check_eq("R7", "commit after squash", ev_k[1], 2);
         check_eq("R7", "commit free preg", ev_c[1], 4);
      end
      clear_log();
      do_commit(11);
      check_eq("R7", "survivor commit count", ev_k.size(), 1);
      if (ev_k.size() == 1) check_eq("R7", "survivor free preg", ev_c[0], 5);
      check_eq("R7", "empty after", int'(empty), 1);
   endtask

   task automatic t_push_in_squash();
      push(20, 7, 50, 7, 1'b0);
      clear_log();
      squash_valid = 1'b1; squash_seq = 16'd19;
      push_valid = 1'b1; push_seq = 16'd21; push_areg = 5'd8;
      push_new_preg = 7'd51; push_old_preg = 7'd8;
      @(negedge clk);
      squash_valid = 1'b0;
      push_seq = 16'd22;
      check_eq("R8", "busy during squash", int'(busy), 1);
      @(negedge clk);
      push_valid = 1'b0;
      wait_idle();
      check_eq("R8", "busy low after walk", int'(busy), 0);
      check_eq("R8", "pushes dropped, log empty", int'(empty), 1);
      check_eq("R3", "one restore", ev_k.size(), 1);
      if (ev_k.size() == 1) check_eq("R3", "restore areg", ev_a[0], 7);
   endtask

   task automatic t_counters();
      check_eq("R9", "cnt_placeholders", int'(cnt_placeholders), 2);
      check_eq("R9", "cnt_commits", int'(cnt_commits), 35);
      check_eq("R9", "cnt_undos", int'(cnt_undos), 5);
      check_eq("R9", "cnt_undos_real", int'(cnt_undos_real), 4);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_commit_walk();
      t_commit_stale();
      t_squash_walk();
      t_squash_empty();
      t_fill();
      t_priority();
      t_push_in_squash();
      t_counters();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule